// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a timer is allowed to advance. It turns a 3-bit select code into a count-enable pulse, `tick_o`, that lasts one system clock cycle. The pulse can come from one of three places. It can come directly from the system clock. It can come from one of four taps on a free-running prescaler that runs on the system clock. It can also come from edges on an external count pin, after those edges pass through a synchronizer. Select 000 turns the pulse off, which stops the timer.

The external pin is read purely as an input. Edges that the chip drives onto the pin itself therefore also advance the timer, and software can clock the timer by toggling the pin. The prescaler never stops and never restarts when the select code changes. A change of division ratio therefore keeps the phase the prescaler already had.

Top module: `tclk_source_sel`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `tick_o` is 0. Reset also clears the prescaler to 0.
- R2: With select 3'b000, `tick_o` stays 0 however long the select is held.
- R3: With select 3'b001, `tick_o` is 1 in every cycle after the first clock edge that follows the select change.
- R4: Selects 3'b010, 3'b011, 3'b100 and 3'b101 give ticks spaced exactly 8, 64, 256 and 1024 cycles apart. Any window of K×N cycles holds exactly K ticks.
- R5: With select 3'b110, each falling edge of `ext_pin_i` gives exactly one tick. Rising edges give none.
- R6: With select 3'b111, each rising edge of `ext_pin_i` gives exactly one tick. Falling edges give none.
- R7: A pin change made between two clock edges shows up as `tick_o` high after the third rising clock edge that follows it. That is between 2 and 3 system cycles after the change.
- R8: The prescaler counts up by one every cycle, whatever the select code. A change of select does not reset it. After a divide-by-64 tick, switching to divide-by-8 gives the next tick exactly 8 cycles later.
- R9: In every mode except 3'b001, each tick is exactly one cycle wide while the select is held steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 3 | Tick source select code |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
A prescaler tap and a change of the select code can land in the same cycle. The bench provokes this by switching from divide-by-64 to divide-by-8 on the sample right after a divide-by-64 tick. It expects the next tick exactly 8 cycles later; a prescaler restarted by the select change would put the tick elsewhere. The other collision is a pin edge arriving while the select names the opposite edge polarity. The bench drives both polarities under each external mode and counts the ticks that appear.

// File: rtl/tclk_pkg.sv
// Shared definitions for the timer tick source selector.
// Assumes the prescaler is at least 10 bits wide so that every tap fits.
package tclk_pkg;

    typedef enum logic [2:0] {
        SEL_OFF      = 3'b000,
        SEL_DIRECT   = 3'b001,
        SEL_DIV8     = 3'b010,
        SEL_DIV64    = 3'b011,
        SEL_DIV256   = 3'b100,
        SEL_DIV1024  = 3'b101,
        SEL_PIN_FALL = 3'b110,
        SEL_PIN_RISE = 3'b111
    } tclk_sel_e;

    localparam int NUM_TAPS = 4;

    // Base-2 exponent of each prescaler tap, in select-code order.
    function automatic int tap_exp(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tclk_prescaler.sv
// Free-running prescaler. It counts up on every clock and wraps.
// Tap g is high for one cycle each time the low tap_exp(g) bits are all ones.
// Assumes tap_exp(g) <= CNT_W for every tap.
module tclk_prescaler #(
    parameter int CNT_W    = 10,
    parameter int NUM_TAPS = tclk_pkg::NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [NUM_TAPS-1:0] tap_o
);

    logic [CNT_W-1:0] cnt_q;

    // Advance the prescaler each cycle; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int E = tclk_pkg::tap_exp(g);
        assign tap_o[g] = &cnt_q[E-1:0];
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tclk_pin_sync.sv
// Brings an asynchronous pin into the clock domain through SYNC_STAGES flops.
// One more flop holds the previous synced level for edge detection.
// Assumes SYNC_STAGES >= 2.
module tclk_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the pin level through the synchronizer and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
    end

    assign lvl_o  = chain_q[SYNC_STAGES-1];
    assign rise_o =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign fall_o = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];

endmodule

// File: rtl/tclk_source_sel.sv
// Top level. Picks the tick source from sel_i and registers the result.
// tick_o therefore reflects the select code of the previous cycle.
// Assumes ext_pin_i may change at any time relative to clk.
module tclk_source_sel #(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    input  logic       ext_pin_i,
    output logic       tick_o
);
    import tclk_pkg::*;

    logic [CNT_W-1:0]    presc_cnt;
    logic [NUM_TAPS-1:0] taps;
    logic                pin_lvl;
    logic                pin_rise;
    logic                pin_fall;
    logic                tick_d;
    logic                tick_q;
    tclk_sel_e           sel;

    tclk_prescaler #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (presc_cnt),
        .tap_o (taps)
    );

    tclk_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign sel = tclk_sel_e'(sel_i);

    // Route the source named by the select code to the tick register.
    always_comb begin
        case (sel)
            SEL_OFF:      tick_d = 1'b0;
            SEL_DIRECT:   tick_d = 1'b1;
            SEL_DIV8:     tick_d = taps[0];
            SEL_DIV64:    tick_d = taps[1];
            SEL_DIV256:   tick_d = taps[2];
            SEL_DIV1024:  tick_d = taps[3];
            SEL_PIN_FALL: tick_d = pin_fall;
            SEL_PIN_RISE: tick_d = pin_rise;
            default:      tick_d = 1'b0;
        endcase
    end

    // Register the tick so that it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/tclk_source_sel_chk.sv
// Checker for the tick source selector. It is bound into the top module
// and looks at the ports, the synced pin level and the prescaler count.
module tclk_source_sel_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel_i,
    input logic             tick_o,
    input logic             pin_sync,
    input logic [CNT_W-1:0] presc_cnt
);

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b000) |=> !tick_o);                                     // R2

    AST_DIRECT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b001) |=> tick_o);                                      // R3

    AST_RISE_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b111 && $rose(pin_sync)) |=> tick_o);                   // R6

    AST_FALL_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b110 && $fell(pin_sync)) |=> tick_o);                   // R5

    AST_PRESC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (presc_cnt == $past(presc_cnt) + 1'b1));                   // R8

    AST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != 3'b001 && $stable(sel_i) && tick_o) |=> !tick_o);         // R9

endmodule

bind tclk_source_sel tclk_source_sel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .tick_o    (tick_o),
    .pin_sync  (pin_lvl),
    .presc_cnt (presc_cnt)
);

// File: tb/tclk_source_sel_test.sv
`timescale 1ns/1ps
// Directed bench for the tick source selector. Inputs change on the falling
// clock edge and outputs are sampled there, away from the active edge.
module tclk_source_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       pin = 1'b0;
    logic       tick;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    tclk_source_sel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .ext_pin_i (pin),
        .tick_o    (tick)
    );

    // Record one check result and print a line if it failed.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait up to lim cycles for a tick; return the cycles waited or -1.
    task automatic wait_tick(input int lim, output int waited);
        waited = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (tick) begin waited = i; break; end
        end
    endtask

    // R1: reset state, with a select that would tick every cycle.
    task automatic t_reset;
        sel = 3'b001;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 tick in reset", tick, 0);
        rst_n = 1'b1;
        check("R1 tick before first edge", tick, 0);
        @(negedge clk);
        check("R1 tick after first edge", tick, 1);
    endtask

    // R2: select 000 never ticks.
    task automatic t_off;
        int n = 0;
        sel = 3'b000;
        @(negedge clk);
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check("R2 ticks while off", n, 0);
    endtask

    // R3: select 001 ticks every cycle.
    task automatic t_direct;
        int n = 0;
        sel = 3'b001;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check("R3 ticks in 40 cycles", n, 40);
    endtask

    // R4, R9: tick spacing, tick width and window count for one divider.
    task automatic t_div(input logic [2:0] code, input int div);
        int w;
        int n = 0;
        sel = code;
        wait_tick(div + 2, w);
        check($sformatf("R4 first tick found div %0d", div), (w > 0) ? 1 : 0, 1);
        @(negedge clk);
        check($sformatf("R9 width div %0d", div), tick, 0);
        wait_tick(div + 2, w);
        check($sformatf("R4 spacing div %0d", div), w + 1, div);
        for (int i = 0; i < 3 * div; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check($sformatf("R4 count in 3N div %0d", div), n, 3);
    endtask

    // R5, R6, R7: one edge of each polarity in an external mode.
    task automatic t_pin(input logic [2:0] code, input logic active_rise);
        int seen [5];
        int n = 0;
        sel = code;
        pin = active_rise ? 1'b0 : 1'b1;
        repeat (6) @(negedge clk);
        pin = ~pin;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            seen[k] = tick;
        end
        check($sformatf("R7 no tick after 2 edges mode %0d", code), seen[2], 0);
        check($sformatf("R7 tick after 3rd edge mode %0d", code), seen[3], 1);
        check($sformatf("R9 pin tick width mode %0d", code), seen[4], 0);
        pin = ~pin;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check(active_rise ? "R6 no tick on falling edge" : "R5 no tick on rising edge", n, 0);
    endtask

    // R5, R6: software toggling counts exactly one tick per chosen edge.
    task automatic t_pin_burst(input logic [2:0] code);
        int n = 0;
        sel = code;
        pin = 1'b0;
        repeat (6) @(negedge clk);
        for (int t = 0; t < 20; t++) begin
            pin = ~pin;
            repeat (3) begin
                @(negedge clk);
                if (tick) n++;
            end
        end
        repeat (6) begin
            @(negedge clk);
            if (tick) n++;
        end
        check(code == 3'b111 ? "R6 ticks for 10 rising edges" : "R5 ticks for 10 falling edges", n, 10);
    endtask

    // R8: a divide-by-64 tick and a switch to divide-by-8 in the same cycle.
    task automatic t_phase;
        int w;
        sel = 3'b011;
        wait_tick(70, w);
        check("R8 div64 tick found", (w > 0) ? 1 : 0, 1);
        sel = 3'b010;
        wait_tick(20, w);
        check("R8 gap after switch to div8", w, 8);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_off();
        t_direct();
        t_div(3'b010, 8);
        t_div(3'b011, 64);
        t_div(3'b100, 256);
        t_div(3'b101, 1024);
        t_pin(3'b110, 1'b0);
        t_pin(3'b111, 1'b1);
        t_pin_burst(3'b110);
        t_pin_burst(3'b111);
        t_phase();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule